// File: doc/BRIEF.md
# Round-Robin Error Record Merger

This block drains many small per-chain error queues into one shared queue that feeds a host link. Each monitored chain owns a first-word-fall-through source FIFO that holds error records (time stamp, error count and the corrupted data word, packed into one opaque record). A scan pointer walks the sources in a fixed circle. On each cycle it visits one source. When that source holds a record and the merged queue has room, it pops the record, prefixes it with the source number and writes it into the merged queue.

The merged queue presents its head on a valid/ready output port. A sticky flag records whether any source FIFO has reported a write while it was full. The scan pointer moves on every cycle whether or not the visited source was empty. It freezes only while the merged queue is full, so back-pressure from the host loses no record.

Top module: `rr_err_merge`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` and `ovf_o` are 0. After reset is released, the first source visited is source 0.
- R2: The scan pointer advances by one each cycle that the merged queue is not full, whether or not the visited source was empty. It wraps from N_SRC-1 to 0, so a lone non-empty source is popped once every N_SRC cycles.
- R3: `src_rd_o` has at most one bit set in any cycle. A bit is set only for the visited source, only when that source is not empty and only when the merged queue is not full.
- R4: A merged record carries the source number in bits [OUT_W-1:REC_W] and the popped record unchanged in bits [REC_W-1:0].
- R5: Records leave the merged port in the order they were popped. With every source holding the same number of records, the output alternates sources 0,1,…,N_SRC-1 and each source's records keep their own order.
- R6: While the merged queue is full, no source is popped and the scan pointer holds. No record is dropped or duplicated across a stall.
- R7: `ovf_o` rises the cycle after any `src_ovf_i` bit is high and stays high until reset.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays stable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_empty_i | input | N_SRC | Empty flag of each source FIFO |
| src_rd_o | output | N_SRC | Pop strobe to each source FIFO |
| src_data_i | input | N_SRC*REC_W | Head record of each source FIFO, source k at bits [k*REC_W +: REC_W] |
| src_ovf_i | input | N_SRC | Per-source pulse: written while full |
| out_valid_o | output | 1 | Merged record available |
| out_ready_i | input | 1 | Host accepts the merged record |
| out_data_o | output | OUT_W | Merged record: source number above the popped record |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A pop strobe is combinational in the visited cycle, and the record it takes becomes visible at the merged port one clock edge later. An overflow pulse appears on `ovf_o` after one edge. The bench moves inputs just after a rising edge and samples on the falling edge. It counts a merged record as delivered only when valid and ready are both high at that falling edge, which is the edge before the transfer completes. Stall behaviour is checked by counting source pops across a long window with ready held low. The pop interval is checked by measuring the cycle distance between successive strobes.

// File: rtl/rr_err_merge_pkg.sv
package rr_err_merge_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_scan.sv
module rr_scan #(
  parameter int N_SRC = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (!hold_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/merge_fifo.sv
module merge_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CNT_FULL);
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sticky_ovf.sv
module sticky_ovf #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  output logic             flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_q | (|hit_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rr_err_merge.sv
module rr_err_merge
  import rr_err_merge_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int REC_W = 16,
  parameter int DEPTH = 4,
  localparam int IDX_W = idx_bits(N_SRC),
  localparam int OUT_W = IDX_W + REC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_empty_i,
  output logic [N_SRC-1:0]       src_rd_o,
  input  logic [N_SRC*REC_W-1:0] src_data_i,
  input  logic [N_SRC-1:0]       src_ovf_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [OUT_W-1:0]       out_data_o,
  output logic                   ovf_o
);
  logic [IDX_W-1:0] scan_idx;
  logic             fifo_full;
  logic [REC_W-1:0] sel_rec;
  logic             push;

  rr_scan #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (fifo_full),
    .idx_o  (scan_idx)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_rd
    assign src_rd_o[g] = (scan_idx == IDX_W'(g)) && !src_empty_i[g] && !fifo_full;
  end

  always_comb begin
    sel_rec = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (scan_idx == IDX_W'(k)) sel_rec = src_data_i[k*REC_W +: REC_W];
    end
  end

  assign push = |src_rd_o;

  merge_fifo #(.W(OUT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i ({scan_idx, sel_rec}),
    .full_o  (fifo_full),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i),
    .rdata_o (out_data_o)
  );

  sticky_ovf #(.N_SRC(N_SRC)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (src_ovf_i),
    .flag_o (ovf_o)
  );
endmodule

// File: rtl/rr_err_merge_chk.sv
module rr_err_merge_chk #(
  parameter int N_SRC = 4,
  parameter int IDX_W = 2,
  parameter int OUT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_empty_i,
  input logic [N_SRC-1:0] src_rd_o,
  input logic [N_SRC-1:0] src_ovf_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             ovf_o,
  input logic             fifo_full,
  input logic [IDX_W-1:0] scan_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  // R3
  rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_rd_o));

  // R3
  rd_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rd_o & src_empty_i) == '0);

  // R6
  full_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> (src_rd_o == '0));

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |=> (scan_idx == $past(scan_idx)));

  // R2
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_full |=> (scan_idx == (($past(scan_idx) == LAST) ? '0 : $past(scan_idx) + 1'b1)));

  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_ovf_i) |=> ovf_o);

  // R7
  ovf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind rr_err_merge rr_err_merge_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_empty_i (src_empty_i),
  .src_rd_o    (src_rd_o),
  .src_ovf_i   (src_ovf_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .ovf_o       (ovf_o),
  .fifo_full   (fifo_full),
  .scan_idx    (scan_idx)
);

// File: tb/rr_err_merge_tb.sv
`timescale 1ns/1ps
module rr_err_merge_tb;
  localparam int N     = 4;
  localparam int RW    = 16;
  localparam int DEPTH = 4;
  localparam int IW    = 2;
  localparam int OW    = IW + RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    src_empty, src_rd, src_ovf;
  logic [N*RW-1:0] src_data;
  logic            out_valid, out_ready, ovf;
  logic [OW-1:0]   out_data;

  rr_err_merge #(.N_SRC(N), .REC_W(RW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_empty_i(src_empty), .src_rd_o(src_rd), .src_data_i(src_data),
    .src_ovf_i(src_ovf),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .ovf_o(ovf)
  );

  int checks = 0, errors = 0;
  int head [N];
  int src_len [N];
  int pop_total;
  logic [OW-1:0] exp_arr [64];
  int exp_n, rx_cnt;
  int cyc, last_rd_cyc;
  bit gap_on;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // source FIFO models
  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_empty[i] = (head[i] >= src_len[i]);
      src_data[i*RW +: RW] = RW'((i << 8) | head[i]);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) head[i] <= 0;
      pop_total <= 0;
    end else begin
      for (int i = 0; i < N; i++) if (src_rd[i]) head[i] <= head[i] + 1;
      pop_total <= pop_total + $countones(src_rd);
    end
  end

  // merged-port monitor and pop interval meter
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && out_valid && out_ready) begin
      if (rx_cnt >= exp_n) check(1'b0, "R6 extra record", longint'(out_data), 0);
      else check(out_data == exp_arr[rx_cnt], "R4/R5 record", longint'(out_data),
                 longint'(exp_arr[rx_cnt]));
      rx_cnt <= rx_cnt + 1;
    end
    if (rst_n && gap_on && src_rd != '0) begin
      if (last_rd_cyc >= 0) check(cyc - last_rd_cyc == N, "R2 pop interval", cyc - last_rd_cyc, N);
      last_rd_cyc <= cyc;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    rx_cnt = 0; last_rd_cyc = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(ovf == 1'b0, "R1 ovf in reset", ovf, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 400 && rx_cnt < n; t++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  function automatic logic [OW-1:0] rec(input int s, input int r);
    return {IW'(s), RW'((s << 8) | r)};
  endfunction

  initial begin
    cyc = 0; gap_on = 0; exp_n = 0; rx_cnt = 0; last_rd_cyc = -1;
    src_ovf = '0; out_ready = 1'b1;
    for (int i = 0; i < N; i++) src_len[i] = 0;

    // T1/T2: all sources hold 5 records, host always ready
    for (int i = 0; i < N; i++) src_len[i] = 5;
    exp_n = N * 5;
    for (int j = 0; j < exp_n; j++) exp_arr[j] = rec(j % N, j / N);
    do_reset();
    @(negedge clk);
    check(src_rd == 4'b0001, "R1 first visit source 0", src_rd, 1);
    wait_rx(exp_n);
    check(rx_cnt == exp_n, "R5 count full load", rx_cnt, exp_n);

    // T3: only source 2 holds records, pops every N cycles
    for (int i = 0; i < N; i++) src_len[i] = 0;
    src_len[2] = 6;
    exp_n = 6;
    for (int j = 0; j < exp_n; j++) exp_arr[j] = rec(2, j);
    do_reset();
    gap_on = 1;
    wait_rx(exp_n);
    gap_on = 0;
    check(rx_cnt == exp_n, "R2 count lone source", rx_cnt, exp_n);

    // T4: sparse mix, sources 1 (2 records) and 3 (3 records)
    for (int i = 0; i < N; i++) src_len[i] = 0;
    src_len[1] = 2; src_len[3] = 3;
    exp_n = 5;
    exp_arr[0] = rec(1, 0); exp_arr[1] = rec(3, 0); exp_arr[2] = rec(1, 1);
    exp_arr[3] = rec(3, 1); exp_arr[4] = rec(3, 2);
    do_reset();
    wait_rx(exp_n);
    check(rx_cnt == exp_n, "R5 count sparse", rx_cnt, exp_n);

    // T5: back-pressure, host stalled then released
    for (int i = 0; i < N; i++) src_len[i] = 6;
    exp_n = N * 6;
    for (int j = 0; j < exp_n; j++) exp_arr[j] = rec(j % N, j / N);
    out_ready = 1'b0;
    do_reset();
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(pop_total == DEPTH, "R6 pops while stalled", pop_total, DEPTH);
    check(out_valid == 1'b1, "R8 valid while stalled", out_valid, 1);
    check(src_rd == '0, "R6 no pop when full", src_rd, 0);
    begin
      logic [OW-1:0] held;
      held = out_data;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(out_data == held && out_valid, "R8 head stable", out_data, held);
      end
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    wait_rx(exp_n);
    check(rx_cnt == exp_n, "R6 no loss across stall", rx_cnt, exp_n);

    // T6: overflow flag
    for (int i = 0; i < N; i++) src_len[i] = 0;
    exp_n = 0;
    do_reset();
    @(negedge clk);
    check(ovf == 1'b0, "R7 ovf clear", ovf, 0);
    @(posedge clk); #1;
    src_ovf = 4'b1000;
    @(posedge clk); #1;
    src_ovf = '0;
    @(negedge clk);
    check(ovf == 1'b1, "R7 ovf set next cycle", ovf, 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(ovf == 1'b1, "R7 ovf sticky", ovf, 1);
    do_reset();
    @(negedge clk);
    check(ovf == 1'b0, "R7 ovf cleared by reset", ovf, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule